// File: doc/BRIEF.md
# DisplayPort AUX Request Controller

This block lets software issue one DisplayPort AUX transaction at a time, either a native transfer or an I2C-over-AUX transfer, and collect what the sink answered. Software programs a target address, fills up to sixteen bytes of outgoing data into four little-endian words, and writes a control word that holds the command, the byte count minus one and a launch bit. While the launch bit is set, the controller presents the request to a link-side handshake port and holds it there until the link answers or a programmable cycle limit runs out.

The reply type, the number of bytes returned, the returned data and the error flags all end up in registers. A done interrupt flag marks the end of every launched transaction. The hot-plug-detect input is debounced, and its rising and falling edges raise plug and unplug flags. A sink-interrupt pulse from the link raises a third flag. Each flag is cleared by writing one to it, and it drives the interrupt line only when its enable bit is set. Line coding and pad control belong to the link side, which this block models as a plain request/response port.

Register map (word index on `reg_addr`): 0 target address, 1 control, 2 status, 3 interrupt flags, 4 interrupt enables, 5 timeout limit, 8 to 11 outgoing data words, 12 to 15 returned data words.

Top module: `auxreq_ctrl`

## Requirements
- R1: After reset the control, status, interrupt flag and interrupt enable registers read 0, the timeout register reads its parameter default (400), and `link_req` and `irq` are low.
- R2: A control write with bit 16 set, while idle and with a legal setting, raises `link_req` from the next cycle. The command from control bits 14:12 (0 native write, 1 native read, 2 I2C write, 3 I2C read, 4 I2C write-status-update) goes on `link_cmd`. Control bit 15 goes on `link_mot` for I2C commands and is forced to 0 for native ones. The address register goes on `link_addr`. Control bit 16 reads 1 until the transaction ends and then reads 0.
- R3: Control bits 3:0 hold the byte count minus one, so `link_len` is that field plus one. Byte j of outgoing word i appears on `link_wdata[32*i+8*j +: 8]`. Byte k of `link_rsp_rdata` lands in returned word k/4 at bit 8*(k mod 4).
- R4: Control bit 8 selects an address-only request. With an I2C command it gives `link_len` 0 and `link_addr_only` high. With a native command the launch bit has no effect: no request is made, bit 16 reads 0 and no done flag is raised.
- R5: Command codes 5 to 7 are never launched.
- R6: When the link answers, status bits 23:16 take `link_rsp_type` (one-hot: 0 native ACK, 1 native NACK, 2 native DEFER, 4 I2C NACK, 8 I2C DEFER) and status bits 4:0 take `link_rsp_count`. The returned data words are loaded only for a read command without the address-only bit whose reply type is 0. Otherwise they keep their old contents.
- R7: `link_rsp_err` bits 0, 1 and 2 set the sticky status flags 9 (receive), 10 (sink status) and 11 (missing stop). The flags persist across later transactions until status is written with ones at those bits; writing 0xF00 clears all error flags.
- R8: If no response arrives, the request ends after the timeout register value plus one cycles of `link_req`. Status bit 8 is set and the done flag is raised.
- R9: Interrupt flag bit 0 (done) is set when any launched transaction ends. Each flag clears when 1 is written to it. `irq` is high exactly when a set flag has its enable bit set.
- R10: Writes to the address, control and outgoing data registers are ignored while a transaction is in progress.
- R11: The hot-plug level shown at status bit 28 follows `hpd_in` only after it has held a new level for the debounce interval. A rise sets flag bit 3 (plug), a fall sets flag bit 2 (unplug), and shorter pulses change nothing.
- R12: A one-cycle `sink_irq` pulse sets flag bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt line, OR of enabled flags |
| hpd_in | input | 1 | Raw hot-plug-detect level |
| sink_irq | input | 1 | One-cycle sink interrupt event from the link |
| link_req | output | 1 | Request pending on the link port |
| link_cmd | output | 3 | Request command code |
| link_mot | output | 1 | I2C middle-of-transaction qualifier |
| link_addr_only | output | 1 | Address-only I2C request |
| link_addr | output | 20 | Target address |
| link_len | output | 5 | Request byte count, 0 to 16 |
| link_wdata | output | 128 | Outgoing bytes, little-endian |
| link_rsp | input | 1 | One-cycle response strobe |
| link_rsp_type | input | 8 | One-hot reply type |
| link_rsp_count | input | 5 | Returned byte count |
| link_rsp_err | input | 3 | Receive, sink-status and missing-stop errors |
| link_rsp_rdata | input | 128 | Returned bytes, little-endian |

## Verification
The timeout edge is the hardest case to reach from the ports, because it needs a request that the link never answers. The bench shortens the limit through the timeout register, holds the response back, and samples `link_req` on the last cycle it must still be high and on the first cycle it must be low. Debounce rejection is reached by driving a hot-plug glitch shorter than the interval after the level has settled, then confirming that neither the level nor the flags move. Random transactions mix every legal command, address-only I2C requests, response delays and all five reply codes. Their expected results come from a bench model of the requirements.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;

   typedef enum logic [2:0] {
      CMD_NAT_WR  = 3'd0,
      CMD_NAT_RD  = 3'd1,
      CMD_I2C_WR  = 3'd2,
      CMD_I2C_RD  = 3'd3,
      CMD_I2C_WSU = 3'd4
   } aux_cmd_e;

   // control word layout
   localparam int CB_LEN_LO = 0;
   localparam int CB_AONLY  = 8;
   localparam int CB_CMD_LO = 12;
   localparam int CB_MOT    = 15;
   localparam int CB_GO     = 16;

   // status word layout
   localparam int SB_ERR_LO = 8;
   localparam int SB_TYP_LO = 16;
   localparam int SB_HPD    = 28;

   // register word indices
   localparam int RA_ADDR  = 0;
   localparam int RA_CTRL  = 1;
   localparam int RA_STAT  = 2;
   localparam int RA_INTST = 3;
   localparam int RA_INTEN = 4;
   localparam int RA_TMO   = 5;
   localparam int RA_TX    = 8;
   localparam int RA_RX    = 12;

   // interrupt flag bits
   localparam int IB_DONE   = 0;
   localparam int IB_SINK   = 1;
   localparam int IB_UNPLUG = 2;
   localparam int IB_PLUG   = 3;

   typedef struct packed {
      logic [2:0] cmd;
      logic       mot;
      logic       aonly;
      logic [3:0] len_m1;
   } ctrl_t;

   function automatic logic cmd_is_i2c(input logic [2:0] c);
      return (c == CMD_I2C_WR) || (c == CMD_I2C_RD) || (c == CMD_I2C_WSU);
   endfunction

   function automatic logic cmd_is_read(input logic [2:0] c);
      return (c == CMD_NAT_RD) || (c == CMD_I2C_RD);
   endfunction

   function automatic logic cmd_defined(input logic [2:0] c);
      return c <= CMD_I2C_WSU;
   endfunction

endpackage

// File: rtl/auxreq_hpd_deb.sv
module auxreq_hpd_deb #(
   parameter int DEB_W      = 8,
   parameter int DEB_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hpd_in,
   output logic level,
   output logic rise_p,
   output logic fall_p
);
   localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_CYCLES - 1);

   logic [1:0]       sync_q;
   logic [DEB_W-1:0] cnt_q;

   if (DEB_CYCLES < 1 || DEB_CYCLES > (1 << DEB_W)) begin : g_bad_deb
      $error("DEB_CYCLES does not fit DEB_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         cnt_q  <= '0;
         level  <= 1'b0;
         rise_p <= 1'b0;
         fall_p <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], hpd_in};
         rise_p <= 1'b0;
         fall_p <= 1'b0;
         if (sync_q[1] != level) begin
            if (cnt_q == DEB_LAST) begin
               level  <= sync_q[1];
               cnt_q  <= '0;
               rise_p <= sync_q[1];
               fall_p <= ~sync_q[1];
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/auxreq_xfer.sv
module auxreq_xfer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             link_rsp,
   output logic             busy,
   output logic             rsp_take,
   output logic             tmo_hit
);
   typedef enum logic {ST_IDLE, ST_WAIT} st_e;

   st_e              st_q;
   logic [TMO_W-1:0] cnt_q;

   assign busy     = (st_q == ST_WAIT);
   assign rsp_take = busy && link_rsp;
   assign tmo_hit  = busy && !link_rsp && (cnt_q == tmo_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (go) begin
               st_q  <= ST_WAIT;
               cnt_q <= '0;
            end
            ST_WAIT: begin
               if (rsp_take || tmo_hit) st_q <= ST_IDLE;
               else                     cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/auxreq_ctrl.sv
module auxreq_ctrl
   import auxreq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int NWORDS     = 4,
   parameter int TMO_W      = 16,
   parameter int TMO_RESET  = 400,
   parameter int DEB_W      = 8,
   parameter int DEB_CYCLES = 16,
   parameter int REG_AW     = 4,
   localparam int NBYTES    = NWORDS * 4,
   localparam int DATA_W    = NBYTES * 8,
   localparam int CNT_W     = $clog2(NBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   input  logic              hpd_in,
   input  logic              sink_irq,
   output logic              link_req,
   output logic [2:0]        link_cmd,
   output logic              link_mot,
   output logic              link_addr_only,
   output logic [ADDR_W-1:0] link_addr,
   output logic [CNT_W-1:0]  link_len,
   output logic [DATA_W-1:0] link_wdata,
   input  logic              link_rsp,
   input  logic [7:0]        link_rsp_type,
   input  logic [CNT_W-1:0]  link_rsp_count,
   input  logic [2:0]        link_rsp_err,
   input  logic [DATA_W-1:0] link_rsp_rdata
);
   // elaboration-time parameter checks
   if (NWORDS < 1 || NWORDS > 4) begin : g_bad_words
      $error("NWORDS must be 1 to 4");
   end
   if (REG_AW < 4) begin : g_bad_aw
      $error("REG_AW must be at least 4");
   end
   if (ADDR_W < 1 || ADDR_W > 32 || TMO_W < 1 || TMO_W > 32) begin : g_bad_w
      $error("ADDR_W and TMO_W must be 1 to 32");
   end

   logic [ADDR_W-1:0] addr_q;
   ctrl_t             ctrl_q;
   logic [31:0]       tx_q [NWORDS];
   logic [31:0]       rx_q [NWORDS];
   logic [7:0]        rtype_q;
   logic [CNT_W-1:0]  rcnt_q;
   logic [3:0]        err_q;
   logic [3:0]        int_q;
   logic [3:0]        inten_q;
   logic [TMO_W-1:0]  tmo_q;

   logic busy, rsp_take, tmo_hit, go;
   logic hpd_lvl, hpd_rise, hpd_fall;
   ctrl_t ctrl_new;
   logic  new_legal, take_rx;
   logic  wr_addr, wr_ctrl, wr_stat, wr_intst, wr_inten, wr_tmo;

   assign wr_addr  = reg_we && (reg_addr == REG_AW'(RA_ADDR));
   assign wr_ctrl  = reg_we && (reg_addr == REG_AW'(RA_CTRL));
   assign wr_stat  = reg_we && (reg_addr == REG_AW'(RA_STAT));
   assign wr_intst = reg_we && (reg_addr == REG_AW'(RA_INTST));
   assign wr_inten = reg_we && (reg_addr == REG_AW'(RA_INTEN));
   assign wr_tmo   = reg_we && (reg_addr == REG_AW'(RA_TMO));

   assign ctrl_new = '{cmd:    reg_wdata[CB_CMD_LO +: 3],
                       mot:    reg_wdata[CB_MOT],
                       aonly:  reg_wdata[CB_AONLY],
                       len_m1: reg_wdata[CB_LEN_LO +: 4]};

   // legality: defined command, address-only only for I2C, length fits buffer
   assign new_legal = cmd_defined(ctrl_new.cmd)
                   && (!ctrl_new.aonly || cmd_is_i2c(ctrl_new.cmd))
                   && (ctrl_new.aonly || (32'(ctrl_new.len_m1) < NBYTES));
   assign go = wr_ctrl && !busy && reg_wdata[CB_GO] && new_legal;

   assign take_rx = rsp_take && (link_rsp_type == 8'h00)
                 && cmd_is_read(ctrl_q.cmd) && !ctrl_q.aonly;

   auxreq_xfer #(.TMO_W(TMO_W)) i_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .tmo_limit (tmo_q),
      .link_rsp  (link_rsp),
      .busy      (busy),
      .rsp_take  (rsp_take),
      .tmo_hit   (tmo_hit)
   );

   auxreq_hpd_deb #(.DEB_W(DEB_W), .DEB_CYCLES(DEB_CYCLES)) i_hpd (
      .clk    (clk),
      .rst_n  (rst_n),
      .hpd_in (hpd_in),
      .level  (hpd_lvl),
      .rise_p (hpd_rise),
      .fall_p (hpd_fall)
   );

   // request-side registers, frozen while busy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         ctrl_q <= '0;
         for (int w = 0; w < NWORDS; w++) tx_q[w] <= '0;
      end else if (!busy) begin
         if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
         if (wr_ctrl) ctrl_q <= ctrl_new;
         for (int w = 0; w < NWORDS; w++)
            if (reg_we && reg_addr == REG_AW'(RA_TX + w)) tx_q[w] <= reg_wdata;
      end
   end

   // reply-side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rtype_q <= '0;
         rcnt_q  <= '0;
         for (int w = 0; w < NWORDS; w++) rx_q[w] <= '0;
      end else if (rsp_take) begin
         rtype_q <= link_rsp_type;
         rcnt_q  <= link_rsp_count;
         if (take_rx)
            for (int w = 0; w < NWORDS; w++) rx_q[w] <= link_rsp_rdata[32*w +: 32];
      end
   end

   // sticky errors and interrupt flags: a new event wins over a clear
   logic [3:0] err_set, int_set, err_clr, int_clr;
   assign err_set = {rsp_take ? link_rsp_err : 3'b000, tmo_hit};
   assign err_clr = wr_stat ? reg_wdata[SB_ERR_LO +: 4] : 4'b0000;
   assign int_set = {hpd_rise, hpd_fall, sink_irq, rsp_take || tmo_hit};
   assign int_clr = wr_intst ? reg_wdata[3:0] : 4'b0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q   <= '0;
         int_q   <= '0;
         inten_q <= '0;
         tmo_q   <= TMO_W'(TMO_RESET);
      end else begin
         err_q <= (err_q & ~err_clr) | err_set;
         int_q <= (int_q & ~int_clr) | int_set;
         if (wr_inten) inten_q <= reg_wdata[3:0];
         if (wr_tmo)   tmo_q   <= reg_wdata[TMO_W-1:0];
      end
   end

   assign irq = |(int_q & inten_q);

   // link-side request fields
   assign link_req       = busy;
   assign link_cmd       = ctrl_q.cmd;
   assign link_mot       = ctrl_q.mot && cmd_is_i2c(ctrl_q.cmd);
   assign link_addr_only = ctrl_q.aonly;
   assign link_addr      = addr_q;
   assign link_len       = ctrl_q.aonly ? '0 : CNT_W'(ctrl_q.len_m1) + CNT_W'(1);

   for (genvar gw = 0; gw < NWORDS; gw++) begin : g_wdata
      assign link_wdata[32*gw +: 32] = tx_q[gw];
   end

   // register read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_AW'(RA_ADDR): reg_rdata[ADDR_W-1:0] = addr_q;
         REG_AW'(RA_CTRL): begin
            reg_rdata[CB_LEN_LO +: 4] = ctrl_q.len_m1;
            reg_rdata[CB_AONLY]       = ctrl_q.aonly;
            reg_rdata[CB_CMD_LO +: 3] = ctrl_q.cmd;
            reg_rdata[CB_MOT]         = ctrl_q.mot;
            reg_rdata[CB_GO]          = busy;
         end
         REG_AW'(RA_STAT): begin
            reg_rdata[CNT_W-1:0]      = rcnt_q;
            reg_rdata[SB_ERR_LO +: 4] = err_q;
            reg_rdata[SB_TYP_LO +: 8] = rtype_q;
            reg_rdata[SB_HPD]         = hpd_lvl;
         end
         REG_AW'(RA_INTST): reg_rdata[3:0] = int_q;
         REG_AW'(RA_INTEN): reg_rdata[3:0] = inten_q;
         REG_AW'(RA_TMO):   reg_rdata[TMO_W-1:0] = tmo_q;
         default: ;
      endcase
      for (int w = 0; w < NWORDS; w++) begin
         if (reg_addr == REG_AW'(RA_TX + w)) reg_rdata = tx_q[w];
         if (reg_addr == REG_AW'(RA_RX + w)) reg_rdata = rx_q[w];
      end
   end
endmodule

// File: rtl/auxreq_ctrl_chk.sv
module auxreq_ctrl_chk #(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 5,
   parameter int REG_AW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_req,
   input logic              link_rsp,
   input logic [2:0]        link_cmd,
   input logic              link_addr_only,
   input logic [ADDR_W-1:0] link_addr,
   input logic [CNT_W-1:0]  link_len,
   input logic [CNT_W-1:0]  link_rsp_count,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              sink_irq,
   input logic              done_flag,
   input logic              sink_flag,
   input logic              plug_flag,
   input logic              hpd_lvl,
   input logic              tmo_flag,
   input logic              rxerr_flag,
   input logic [CNT_W-1:0]  rcnt
);
   logic rxerr_clear;
   assign rxerr_clear = reg_we && (reg_addr == REG_AW'(2)) && reg_wdata[9];

   AST_REQ_DROPS_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      link_req && link_rsp |=> !link_req); // R2
   AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      link_req |-> link_len <= CNT_W'(16)); // R3
   AST_ADDR_ONLY_I2C: assert property (@(posedge clk) disable iff (!rst_n)
      link_req && link_addr_only |-> (link_len == '0) && (link_cmd >= 3'd2)); // R4
   AST_CMD_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
      link_req |-> link_cmd <= 3'd4); // R5
   AST_COUNT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      link_req && link_rsp |=> rcnt == $past(link_rsp_count)); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rxerr_flag && !rxerr_clear |=> rxerr_flag); // R7
   AST_TMO_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> $fell(link_req)); // R8
   AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_req) |-> done_flag); // R9
   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      link_req && !link_rsp |=> $stable(link_addr) && $stable(link_len) && $stable(link_cmd)); // R10
   AST_PLUG_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hpd_lvl) |=> plug_flag); // R11
   AST_SINK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      sink_irq |=> sink_flag); // R12
endmodule

bind auxreq_ctrl auxreq_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .link_req       (link_req),
   .link_rsp       (link_rsp),
   .link_cmd       (link_cmd),
   .link_addr_only (link_addr_only),
   .link_addr      (link_addr),
   .link_len       (link_len),
   .link_rsp_count (link_rsp_count),
   .reg_we         (reg_we),
   .reg_addr       (reg_addr),
   .reg_wdata      (reg_wdata),
   .sink_irq       (sink_irq),
   .done_flag      (int_q[0]),
   .sink_flag      (int_q[1]),
   .plug_flag      (int_q[3]),
   .hpd_lvl        (hpd_lvl),
   .tmo_flag       (err_q[0]),
   .rxerr_flag     (err_q[1]),
   .rcnt           (rcnt_q)
);

// File: tb/test_auxreq_ctrl.sv
module test_auxreq_ctrl;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         irq;
   logic         hpd_in = 1'b0;
   logic         sink_irq = 1'b0;
   logic         link_req, link_mot, link_addr_only;
   logic [2:0]   link_cmd;
   logic [19:0]  link_addr;
   logic [4:0]   link_len;
   logic [127:0] link_wdata;
   logic         link_rsp = 1'b0;
   logic [7:0]   link_rsp_type = '0;
   logic [4:0]   link_rsp_count = '0;
   logic [2:0]   link_rsp_err = '0;
   logic [127:0] link_rsp_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0]  rv;
   logic [127:0] exp_rx = '0;

   always #4 clk = ~clk;

   auxreq_ctrl i_auxreq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .hpd_in(hpd_in),
      .sink_irq(sink_irq), .link_req(link_req), .link_cmd(link_cmd),
      .link_mot(link_mot), .link_addr_only(link_addr_only), .link_addr(link_addr),
      .link_len(link_len), .link_wdata(link_wdata), .link_rsp(link_rsp),
      .link_rsp_type(link_rsp_type), .link_rsp_count(link_rsp_count),
      .link_rsp_err(link_rsp_err), .link_rsp_rdata(link_rsp_rdata)
   );

   function automatic logic m_i2c(input logic [2:0] c);
      return c == 3'd2 || c == 3'd3 || c == 3'd4;
   endfunction
   function automatic logic m_read(input logic [2:0] c);
      return c == 3'd1 || c == 3'd3;
   endfunction
   function automatic logic [31:0] mk_ctrl(input logic [2:0] c, input logic mot,
                                           input logic ao, input logic [3:0] lm1, input logic go);
      return {15'b0, go, mot, c, 3'b0, ao, 4'b0, lm1};
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 rv = reg_rdata;
   endtask

   task automatic respond(input logic [7:0] t, input logic [4:0] c,
                          input logic [2:0] e, input logic [127:0] d);
      @(negedge clk);
      link_rsp = 1'b1; link_rsp_type = t; link_rsp_count = c;
      link_rsp_err = e; link_rsp_rdata = d;
      @(negedge clk);
      link_rsp = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1); chk("R1 ctrl", rv, 0);
      rd(2); chk("R1 stat", rv, 0);
      rd(3); chk("R1 intst", rv, 0);
      rd(4); chk("R1 inten", rv, 0);
      rd(5); chk("R1 tmo", rv, 400);
      chk("R1 link_req/irq", {link_req, irq}, 0);

      // R2 R3 native write, 3 bytes
      wr(8, 32'h44332211); wr(9, 32'h88776655);
      wr(0, 32'h12345);
      wr(1, mk_ctrl(3'd0, 1'b1, 1'b0, 4'd2, 1'b1));
      chk("R2 req up", link_req, 1);
      chk("R2 addr", link_addr, 20'h12345);
      chk("R2 cmd/mot forced 0 native", {link_cmd, link_mot}, {3'd0, 1'b0});
      chk("R3 len", link_len, 3);
      chk("R3 byte order", link_wdata[63:0], 64'h8877665544332211);
      rd(1); chk("R2 go reads 1", rv[16], 1);
      // R10 writes ignored while busy
      wr(0, 32'hABCDE); wr(8, 32'hDEADBEEF); wr(1, mk_ctrl(3'd1, 1'b0, 1'b0, 4'd9, 1'b1));
      chk("R10 addr held", link_addr, 20'h12345);
      chk("R10 data held", link_wdata[31:0], 32'h44332211);
      chk("R10 len/cmd held", {link_len, link_cmd}, {5'd3, 3'd0});
      respond(8'h00, 5'd0, 3'b000, '0);
      chk("R2 req drops", link_req, 0);
      rd(1); chk("R2 go clears", rv[16], 0);
      rd(0); chk("R10 addr reg", rv, 32'h12345);
      rd(3); chk("R9 done set", rv[0], 1);
      chk("R9 irq masked", irq, 0);
      wr(4, 32'h1);
      chk("R9 irq enabled", irq, 1);
      wr(3, 32'h1);
      rd(3); chk("R9 done w1c", rv[0], 0);
      chk("R9 irq cleared", irq, 0);

      // R3 R6 native read of 16 bytes
      wr(1, mk_ctrl(3'd1, 1'b0, 1'b0, 4'd15, 1'b1));
      chk("R3 len 16", link_len, 16);
      begin
         logic [127:0] d;
         for (int k = 0; k < 16; k++) d[8*k +: 8] = 8'(8'hA0 + k);
         respond(8'h00, 5'd16, 3'b000, d);
         exp_rx = d;
      end
      rd(13); chk("R3 rx word1", rv, 32'hA7A6A5A4);
      rd(2); chk("R6 type/count", {rv[23:16], rv[4:0]}, {8'h00, 5'd16});
      wr(3, 32'h1);

      // R6 DEFER keeps rx
      wr(1, mk_ctrl(3'd3, 1'b1, 1'b0, 4'd3, 1'b1));
      chk("R2 mot on i2c", link_mot, 1);
      respond(8'h08, 5'd4, 3'b000, {4{32'h01020304}});
      rd(12); chk("R6 rx kept on defer", rv, exp_rx[31:0]);
      rd(2); chk("R6 defer type", rv[23:16], 8'h08);
      wr(3, 32'h1);

      // R4 address-only I2C
      wr(1, mk_ctrl(3'd2, 1'b0, 1'b1, 4'd7, 1'b1));
      chk("R4 aonly i2c", {link_req, link_addr_only, link_len}, {1'b1, 1'b1, 5'd0});
      respond(8'h04, 5'd0, 3'b000, '0);
      wr(3, 32'h1);
      // R4 address-only native: refused
      wr(1, mk_ctrl(3'd1, 1'b0, 1'b1, 4'd0, 1'b1));
      chk("R4 native aonly no req", link_req, 0);
      rd(1); chk("R4 go reads 0", rv[16], 0);
      rd(3); chk("R4 no done", rv[0], 0);
      // R5 undefined command
      wr(1, mk_ctrl(3'd6, 1'b0, 1'b0, 4'd0, 1'b1));
      chk("R5 cmd 6 no req", link_req, 0);
      rd(3); chk("R5 no done", rv[0], 0);

      // R7 sticky errors
      wr(1, mk_ctrl(3'd0, 1'b0, 1'b0, 4'd0, 1'b1));
      respond(8'h00, 5'd0, 3'b101, '0);
      rd(2); chk("R7 err bits", rv[11:8], 4'b1010);
      wr(1, mk_ctrl(3'd0, 1'b0, 1'b0, 4'd0, 1'b1));
      respond(8'h00, 5'd0, 3'b010, '0);
      rd(2); chk("R7 sticky", rv[11:8], 4'b1110);
      wr(2, 32'hF00);
      rd(2); chk("R7 clear", rv[11:8], 4'b0000);
      wr(3, 32'h1);

      // R8 timeout with limit 20
      wr(5, 32'd20);
      wr(1, mk_ctrl(3'd1, 1'b0, 1'b0, 4'd0, 1'b1));
      chk("R8 req at start", link_req, 1);
      repeat (20) @(negedge clk);
      chk("R8 req at last cycle", link_req, 1);
      @(negedge clk);
      chk("R8 req ends", link_req, 0);
      rd(2); chk("R8 tmo flag", rv[8], 1);
      rd(3); chk("R8 done", rv[0], 1);
      wr(2, 32'hF00); wr(3, 32'h1); wr(5, 32'd400);

      // R11 hot-plug debounce
      @(negedge clk) hpd_in = 1'b1;
      repeat (10) @(negedge clk);
      rd(2); chk("R11 not yet", rv[28], 0);
      repeat (20) @(negedge clk);
      rd(2); chk("R11 level up", rv[28], 1);
      rd(3); chk("R11 plug", rv[3:2], 2'b10);
      wr(3, 32'hC);
      @(negedge clk) hpd_in = 1'b0;
      repeat (5) @(negedge clk);
      hpd_in = 1'b1;
      repeat (30) @(negedge clk);
      rd(2); chk("R11 glitch level", rv[28], 1);
      rd(3); chk("R11 glitch flags", rv[3:2], 2'b00);
      hpd_in = 1'b0;
      repeat (30) @(negedge clk);
      rd(2); chk("R11 level down", rv[28], 0);
      rd(3); chk("R11 unplug", rv[3:2], 2'b01);
      wr(3, 32'hC);

      // R12 sink event
      @(negedge clk) sink_irq = 1'b1;
      @(negedge clk) sink_irq = 1'b0;
      rd(3); chk("R12 sink flag", rv[1], 1);
      wr(3, 32'h2);

      // random transactions
      for (int t = 0; t < 40; t++) begin
         logic [2:0]   c;
         logic         mot, ao;
         logic [3:0]   lm1;
         logic [19:0]  a;
         logic [127:0] tx, d;
         logic [7:0]   typ;
         logic [4:0]   cnt;
         c   = 3'($urandom_range(0, 4));
         mot = 1'($urandom_range(0, 1));
         ao  = m_i2c(c) && ($urandom_range(0, 3) == 0);
         lm1 = 4'($urandom_range(0, 15));
         a   = 20'($urandom);
         for (int w = 0; w < 4; w++) begin
            tx[32*w +: 32] = $urandom;
            wr(8 + w, tx[32*w +: 32]);
         end
         wr(0, {12'b0, a});
         wr(1, mk_ctrl(c, mot, ao, lm1, 1'b1));
         chk("R2 rnd req", link_req, 1);
         chk("R2 rnd cmd/mot", {link_cmd, link_mot}, {c, mot && m_i2c(c)});
         chk("R2 rnd addr", link_addr, a);
         chk("R3 R4 rnd len", {link_addr_only, link_len}, {ao, ao ? 5'd0 : 5'(lm1) + 5'd1});
         chk("R3 rnd wdata", link_wdata, tx);
         repeat ($urandom_range(0, 10)) @(negedge clk);
         case ($urandom_range(0, 4))
            0: typ = 8'h00; 1: typ = 8'h01; 2: typ = 8'h02; 3: typ = 8'h04; default: typ = 8'h08;
         endcase
         cnt = 5'($urandom_range(0, 16));
         d = {$urandom, $urandom, $urandom, $urandom};
         respond(typ, cnt, 3'b000, d);
         if (typ == 8'h00 && m_read(c) && !ao) exp_rx = d;
         rd(2); chk("R6 rnd stat", {rv[23:16], rv[11:8], rv[4:0]}, {typ, 4'b0, cnt});
         for (int w = 0; w < 4; w++) begin
            rd(12 + w); chk("R6 rnd rx", rv, exp_rx[32*w +: 32]);
         end
         rd(3); chk("R9 rnd done", rv[0], 1);
         wr(3, 32'h1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule